// File: doc/BRIEF.md
# Video Digitizer Control Register Bank

This block is the byte-wide control store of a video digitizer's digital control section. A host writes and reads 8-bit registers over a plain synchronous bus. The block assembles the register contents into the wide values and flags that the neighbouring blocks consume:

- a 10-bit offset word for each of the red, green and blue channels;
- a 14-bit line-length value for the sampling PLL;
- a 6-bit sampling-phase code, where one step is 1/64 of a pixel period;
- the coast line counts taken before and after vertical sync;
- five PLL option flags;
- the clamp start pixel and the clamp width.

The line-length value is split across two bytes. The high byte is written into a staging register. The value seen by the PLL changes only when the low byte is written: at that moment the staged high part and the new low byte move into the live register together, so the PLL never sees a half-updated length. Each offset word keeps its eight upper bits in one byte. Its two lowest bits sit at bits 7:6 of the following byte.

Top module: `vfe_ctl_regs`

## Requirements
- R1: Channel offsets are assembled as follows:
  - red is {byte 0x00, bits 7:6 of byte 0x01};
  - green is {byte 0x02, bits 7:6 of byte 0x03};
  - blue is {byte 0x04, bits 7:6 of byte 0x05}.
- R2: After reset, each offset high byte holds 0x80 and each offset low byte holds 0x00, so every offset output is 0x200.
- R3: Address 0x06 stores the line-length high part in bits 5:0 into a staging register. A write to 0x06 alone leaves `lineLength` unchanged.
- R4: A write to address 0x07 loads `lineLength` with {staged bits 5:0, written byte}. The new value is visible from the cycle after the write.
- R5: After reset, `lineLength` is 0x0698, the staged high byte reads 0x06 and the low byte reads 0x98.
- R6: The following registers drive their outputs directly:
  - address 0x08, bits 5:0, drives `samplePhase`;
  - address 0x09 drives `preCoast`;
  - address 0x0A drives `postCoast`.
  After reset, `samplePhase` is 0 and both coast counts are 4.
- R7: Address 0x0B is the option byte. Its bits map as follows, and after reset all five flags are 0:

  | Bit | Output | Meaning when 1 |
  |---|---|---|
  | 0 | `lockLeading` | lock to the leading sync edge (0 selects the trailing edge) |
  | 1 | `clkInvEn` | clock-invert input enabled |
  | 2 | `extCoastSel` | coast taken from the external source |
  | 3 | `extCoastActLow` | external coast is active low |
  | 4 | `extPixClk` | external pixel clock used |

- R8: `clampStart` is {bits 5:0 of 0x0C, byte 0x0D} and resets to 0x0002. `clampWidth` is byte 0x0E and resets to 0x10.
- R9: A read returns the stored byte on `rdData` in the cycle after `rdEn`. Unused bits read as 0, and address 0x06 returns the staged high byte. `rdData` holds its value between reads.
- R10: Addresses 0x0F to 0xFF are undefined. Writes to them change no register and no output, and reads from them return 0x00.
- R11: A write to any register from 0x00 to 0x0E other than 0x06 shows on that register's outputs in the cycle after `wrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Registered read byte |
| redOffset | output | 10 | Red offset word |
| greenOffset | output | 10 | Green offset word |
| blueOffset | output | 10 | Blue offset word |
| lineLength | output | 14 | Committed PLL line length |
| samplePhase | output | 6 | Sampling phase code |
| preCoast | output | 8 | Coast lines before vertical sync |
| postCoast | output | 8 | Coast lines after vertical sync |
| lockLeading | output | 1 | Lock to leading sync edge |
| clkInvEn | output | 1 | Clock-invert input enable |
| extCoastSel | output | 1 | External coast source select |
| extCoastActLow | output | 1 | External coast active low |
| extPixClk | output | 1 | External pixel clock select |
| clampStart | output | 14 | Clamp and black-level start pixel |
| clampWidth | output | 8 | Clamp width |

## Verification
A wrong stored byte shows on its assembled output one cycle after the write, and on `rdData` one cycle after a read of that address. A faulty staging path shows up in two ways. Either `lineLength` moves on a high-byte write, when it should not, or it takes the wrong upper bits on the next low-byte write, one cycle after that write. A decode fault that aliases an undefined address onto a real register shows as a changed output or a non-zero read straight after the stray access.

// File: rtl/vfe_ctl_pkg.sv
package vfe_ctl_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 15;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int NUM_CH   = 3;
  localparam int OFF_W    = 10;
  localparam int OFF_LO_W = OFF_W - DATA_W;
  localparam int LEN_W    = 14;
  localparam int LEN_HI_W = LEN_W - DATA_W;
  localparam int PHASE_W  = 6;
  localparam int OPT_W    = 5;

  localparam int IDX_LEN_HI   = 6;
  localparam int IDX_LEN_LO   = 7;
  localparam int IDX_PHASE    = 8;
  localparam int IDX_PRECOAST = 9;
  localparam int IDX_POSTCST  = 10;
  localparam int IDX_OPT      = 11;
  localparam int IDX_CLMP_HI  = 12;
  localparam int IDX_CLMP_LO  = 13;
  localparam int IDX_CLMP_WID = 14;

  localparam logic [LEN_W-1:0] LEN_RESET = 14'h0698;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic                commitLen;
    logic                rdStrobe;
    logic                rdHit;
    logic [IDX_W-1:0]    rdIdx;
  } ctlStrobe_t;

  function automatic logic [DATA_W-1:0] regReset(input int idx);
    case (idx)
      0, 2, 4:      regReset = 8'h80;
      IDX_LEN_HI:   regReset = LEN_RESET[LEN_W-1:DATA_W];
      IDX_LEN_LO:   regReset = LEN_RESET[DATA_W-1:0];
      IDX_PRECOAST: regReset = 8'h04;
      IDX_POSTCST:  regReset = 8'h04;
      IDX_CLMP_LO:  regReset = 8'h02;
      IDX_CLMP_WID: regReset = 8'h10;
      default:      regReset = '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regMask(input int idx);
    case (idx)
      1, 3, 5:                             regMask = 8'hC0;
      IDX_LEN_HI, IDX_PHASE, IDX_CLMP_HI:  regMask = 8'h3F;
      IDX_OPT:                             regMask = 8'h1F;
      default:                             regMask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/vfe_ctl_decode.sv
module vfe_ctl_decode
  import vfe_ctl_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = (addr <= LAST_ADDR);
  assign idx = addr[IDX_W-1:0];

  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      strobe.wrSel[i] = wrEn && hit && (idx == IDX_W'(i));
    end
    strobe.commitLen = wrEn && hit && (idx == IDX_W'(IDX_LEN_LO));
    strobe.rdStrobe  = rdEn;
    strobe.rdHit     = hit;
    strobe.rdIdx     = idx;
  end
endmodule

// File: rtl/vfe_ctl_datapath.sv
module vfe_ctl_datapath
  import vfe_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [OFF_W-1:0]   chOffset [NUM_CH],
  output logic [LEN_W-1:0]   lineLength,
  output logic [PHASE_W-1:0] samplePhase,
  output logic [DATA_W-1:0]  preCoast,
  output logic [DATA_W-1:0]  postCoast,
  output logic [OPT_W-1:0]   optFlags,
  output logic [LEN_W-1:0]   clampStart,
  output logic [DATA_W-1:0]  clampWidth
);
  logic [DATA_W-1:0] regBytes [NUM_REGS];
  logic [DATA_W-1:0] rdMux;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                q <= regReset(i);
      else if (strobe.wrSel[i]) q <= wrData & regMask(i);
    end
    assign regBytes[i] = q;
  end

  // live line length: staged high part and new low byte land together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lineLength <= LEN_RESET;
    else if (strobe.commitLen) lineLength <= {regBytes[IDX_LEN_HI][LEN_HI_W-1:0], wrData};
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strobe.rdIdx == IDX_W'(i)) rdMux = regBytes[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strobe.rdStrobe) rdData <= strobe.rdHit ? rdMux : '0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign chOffset[c] = {regBytes[2*c], regBytes[2*c+1][DATA_W-1 -: OFF_LO_W]};
  end

  assign samplePhase = regBytes[IDX_PHASE][PHASE_W-1:0];
  assign preCoast    = regBytes[IDX_PRECOAST];
  assign postCoast   = regBytes[IDX_POSTCST];
  assign optFlags    = regBytes[IDX_OPT][OPT_W-1:0];
  assign clampStart  = {regBytes[IDX_CLMP_HI][LEN_HI_W-1:0], regBytes[IDX_CLMP_LO]};
  assign clampWidth  = regBytes[IDX_CLMP_WID];
endmodule

// File: rtl/vfe_ctl_regs.sv
module vfe_ctl_regs
  import vfe_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [OFF_W-1:0]   redOffset,
  output logic [OFF_W-1:0]   greenOffset,
  output logic [OFF_W-1:0]   blueOffset,
  output logic [LEN_W-1:0]   lineLength,
  output logic [PHASE_W-1:0] samplePhase,
  output logic [DATA_W-1:0]  preCoast,
  output logic [DATA_W-1:0]  postCoast,
  output logic               lockLeading,
  output logic               clkInvEn,
  output logic               extCoastSel,
  output logic               extCoastActLow,
  output logic               extPixClk,
  output logic [LEN_W-1:0]   clampStart,
  output logic [DATA_W-1:0]  clampWidth
);
  ctlStrobe_t       strobe;
  logic [OFF_W-1:0] chOffset [NUM_CH];
  logic [OPT_W-1:0] optFlags;

  vfe_ctl_decode u_decode (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe)
  );

  vfe_ctl_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (wrData),
    .rdData      (rdData),
    .chOffset    (chOffset),
    .lineLength  (lineLength),
    .samplePhase (samplePhase),
    .preCoast    (preCoast),
    .postCoast   (postCoast),
    .optFlags    (optFlags),
    .clampStart  (clampStart),
    .clampWidth  (clampWidth)
  );

  assign redOffset      = chOffset[0];
  assign greenOffset    = chOffset[1];
  assign blueOffset     = chOffset[2];
  assign lockLeading    = optFlags[0];
  assign clkInvEn       = optFlags[1];
  assign extCoastSel    = optFlags[2];
  assign extCoastActLow = optFlags[3];
  assign extPixClk      = optFlags[4];
endmodule

// File: rtl/vfe_ctl_regs_chk.sv
module vfe_ctl_regs_chk
  import vfe_ctl_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic [OFF_W-1:0]   redOffset,
  input logic [LEN_W-1:0]   lineLength,
  input logic [OPT_W-1:0]   optFlags
);
  p_len_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 8'h07) |=> $stable(lineLength));

  p_len_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h07) |=> lineLength[DATA_W-1:0] == $past(wrData));

  p_red_msb_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h00) |=> redOffset[OFF_W-1:OFF_LO_W] == $past(wrData));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 8'h01) |=> rdData[5:0] == 6'd0);

  p_undef_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr >= 8'h0F) |=> rdData == 8'h00);

  p_opt_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr >= 8'h0F) |=> $stable(optFlags) && $stable(redOffset));
endmodule

bind vfe_ctl_regs vfe_ctl_regs_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .addr       (addr),
  .wrData     (wrData),
  .rdData     (rdData),
  .redOffset  (redOffset),
  .lineLength (lineLength),
  .optFlags   (optFlags)
);

// File: tb/vfe_ctl_regs_bench.sv
module vfe_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [9:0]  redOffset, greenOffset, blueOffset;
  logic [13:0] lineLength, clampStart;
  logic [5:0]  samplePhase;
  logic [7:0]  preCoast, postCoast, clampWidth;
  logic        lockLeading, clkInvEn, extCoastSel, extCoastActLow, extPixClk;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  vfe_ctl_regs u_vfe_ctl_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .redOffset(redOffset),
    .greenOffset(greenOffset), .blueOffset(blueOffset),
    .lineLength(lineLength), .samplePhase(samplePhase),
    .preCoast(preCoast), .postCoast(postCoast), .lockLeading(lockLeading),
    .clkInvEn(clkInvEn), .extCoastSel(extCoastSel),
    .extCoastActLow(extCoastActLow), .extPixClk(extPixClk),
    .clampStart(clampStart), .clampWidth(clampWidth)
  );

  // {address, write byte, expected read byte}
  localparam logic [23:0] VEC [15] = '{
    24'h00_5A_5A, 24'h01_FF_C0, 24'h02_13_13, 24'h03_40_40, 24'h04_A7_A7,
    24'h05_3F_00, 24'h08_FF_3F, 24'h09_11_11, 24'h0A_EE_EE, 24'h0B_FF_1F,
    24'h0C_FF_3F, 24'h0D_34_34, 24'h0E_00_00, 24'h06_FF_3F, 24'h07_21_21
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic checkDefaults();
    logic [7:0] r;
    check("R2 red reset", 32'(redOffset), 32'h200);
    check("R2 green reset", 32'(greenOffset), 32'h200);
    check("R2 blue reset", 32'(blueOffset), 32'h200);
    check("R5 line length reset", 32'(lineLength), 32'h0698);
    check("R6 phase reset", 32'(samplePhase), 32'h0);
    check("R6 coast reset", 32'({preCoast, postCoast}), 32'h0404);
    check("R7 options reset", 32'({lockLeading, clkInvEn, extCoastSel, extCoastActLow, extPixClk}), 32'h0);
    check("R8 clamp reset", 32'({clampStart, clampWidth}), 32'({14'h0002, 8'h10}));
    rd(8'h00, r); check("R2 read red high byte", 32'(r), 32'h80);
    rd(8'h06, r); check("R5 read staged high", 32'(r), 32'h06);
    rd(8'h07, r); check("R5 read low byte", 32'(r), 32'h98);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkDefaults();

    // R9 R11: table of writes and read-backs
    for (int i = 0; i < 15; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], r);
      check("R9 table read-back", 32'({VEC[i][23:16], r}), 32'({VEC[i][23:16], VEC[i][7:0]}));
    end
    check("R1 red assembled", 32'(redOffset), 32'h16B);
    check("R1 green assembled", 32'(greenOffset), 32'h04D);
    check("R1 blue assembled", 32'(blueOffset), 32'h29C);
    check("R4 line length commit", 32'(lineLength), 32'h3F21);
    check("R6 phase/coasts", 32'({samplePhase, preCoast, postCoast}), 32'({6'h3F, 8'h11, 8'hEE}));
    check("R7 all options set", 32'({lockLeading, clkInvEn, extCoastSel, extCoastActLow, extPixClk}), 32'h1F);
    check("R8 clamp fields", 32'({clampStart, clampWidth}), 32'({14'h3F34, 8'h00}));

    // R7: individual bit positions
    wr(8'h0B, 8'h05);
    check("R7 option bits 0 and 2", 32'({lockLeading, clkInvEn, extCoastSel, extCoastActLow, extPixClk}), 32'b10100);
    wr(8'h0B, 8'h1A);
    check("R7 option bits 1 3 4", 32'({lockLeading, clkInvEn, extCoastSel, extCoastActLow, extPixClk}), 32'b01011);

    // R11: output changes in the cycle after the write strobe
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h09; wrData = 8'h77;
    @(posedge clk); #1;
    check("R11 preCoast next cycle", 32'(preCoast), 32'h77);
    @(negedge clk);
    wrEn = 1'b0;

    // R3 R4: staging of the line length
    doReset();
    wr(8'h06, 8'h12);
    check("R3 high write alone holds", 32'(lineLength), 32'h0698);
    rd(8'h06, r); check("R3 staged high readable", 32'(r), 32'h12);
    wr(8'h07, 8'hAB);
    check("R4 commit staged+low", 32'(lineLength), 32'h12AB);
    wr(8'h06, 8'hC1);
    check("R3 high write masked and held", 32'(lineLength), 32'h12AB);
    wr(8'h07, 8'h00);
    check("R4 second commit", 32'(lineLength), 32'h0100);

    // R10: undefined addresses
    wr(8'h0F, 8'hFF);
    wr(8'h8B, 8'hFF);
    wr(8'hFF, 8'h00);
    check("R10 undefined writes leave outputs", 32'({redOffset, lockLeading, extPixClk, clampWidth}),
          32'({10'h200, 1'b0, 1'b0, 8'h10}));
    check("R10 undefined writes leave line length", 32'(lineLength), 32'h0100);
    rd(8'h0F, r); check("R10 undefined read 0x0F", 32'(r), 32'h00);
    rd(8'h80, r); check("R10 undefined read 0x80", 32'(r), 32'h00);
    rd(8'h0B, r); check("R10 option byte untouched", 32'(r), 32'h00);

    // R9: rdData holds between reads
    rd(8'h0E, r);
    repeat (3) @(negedge clk);
    check("R9 rdData holds", 32'(rdData), 32'h10);

    doReset();
    checkDefaults();

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule